// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching translation entries from memory. A translation request names the virtual address and whether the access is a write and whether it comes from user mode. The walker reads one entry from the page directory, whose base address is given on an input. Unless that entry maps a 4 MB page directly, it then reads one entry from a page table. It checks presence and access rights, and it returns the physical address or a fault code.

When a walk succeeds, the walker marks the entries it used as accessed. On a write it also marks the final entry as modified. It does this through a word write port, and only when an entry actually changes. The walker handles one translation at a time. It takes no new request until the current one has been answered.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both high. `req_valid` held high during a walk starts nothing, and the response belongs to the address that was taken.
- R2: The directory entry is read at `base_addr + 4*VA[31:22]`. The table entry is read at `{PDE[31:12], VA[21:12], 2'b00}`.
- R3: When a walk through both levels succeeds, the response gives `rsp_paddr = {PTE[31:12], VA[11:0]}`, `rsp_level = 2` and `rsp_large = 0`.
- R4: A directory entry with bit 7 set ends the walk without a table read. The response gives `rsp_paddr = {PDE[31:22], VA[21:0]}`, `rsp_level = 1` and `rsp_large = 1`.
- R5: If bit 0 (present) of an entry is clear, the walk stops with `rsp_fault = 1` and `rsp_level` set to that entry's level (1 = directory, 2 = table). `rsp_paddr` is 0 and no memory write is made. Presence is checked before permissions.
- R6: Bit 1 set means writable and bit 2 set means user-accessible. A write fails if bit 1 is clear in any entry used. A user access fails if bit 2 is clear in any entry used, while a supervisor access ignores bit 2. A failure gives `rsp_fault = 2`, the level reached, `rsp_paddr = 0` and no write. `rsp_fault = 0` means success.
- R7: After a successful walk, each entry used has bit 5 (accessed) set. A write access also sets bit 6 (modified) in the final entry only. An entry is written back only if its value changes, and the directory entry is written before the table entry.
- R8: A write-back changes no bit other than bits 5 and 6. Bits 9 to 11 have no effect on the result and are kept unchanged.
- R9: `mem_rd_valid` and `mem_rd_addr` stay stable until `mem_rd_ack`. `mem_wr_valid`, `mem_wr_addr` and `mem_wr_data` stay stable until `mem_wr_ack`. A read and a write are never requested in the same cycle.
- R10: After reset the walker is idle, with `req_ready = 1` and no memory request or response. `rsp_valid` is a pulse one cycle long, and the walker is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 32 | Physical address of the page directory |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 protection |
| rsp_level | output | 2 | Level of the final entry examined |
| rsp_large | output | 1 | Translation used a 4 MB page |
| mem_rd_valid | output | 1 | Read request |
| mem_rd_addr | output | 32 | Read word address (byte address) |
| mem_rd_ack | input | 1 | Read done, data valid this cycle |
| mem_rd_data | input | 32 | Read data |
| mem_wr_valid | output | 1 | Write request |
| mem_wr_addr | output | 32 | Write word address (byte address) |
| mem_wr_data | output | 32 | Write data |
| mem_wr_ack | input | 1 | Write done |

## Verification
The hardest case to reach is the two-write sequence. It needs a present directory entry and a present table entry, with rights that allow the access, and with the accessed or modified bits clear in both. Only then does the walker write back the directory entry and then the table entry. The random table fill biases entries toward present and leaves the flag bits random, so this sequence occurs often. The memory model answers each request after a random delay, which moves the acknowledge edges around. Directed cases add a large page written with its flags clear, an entry with bits 9 to 11 set, and a request held asserted for the whole walk.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_RD_TBL, ST_WR_DIR, ST_WR_LAST, ST_RESP
  } walk_state_t;

  localparam int BIT_P   = 0;
  localparam int BIT_RW  = 1;
  localparam int BIT_US  = 2;
  localparam int BIT_ACC = 5;
  localparam int BIT_DRT = 6;
  localparam int BIT_PS  = 7;

  localparam logic [1:0] FLT_NONE   = 2'd0;
  localparam logic [1:0] FLT_ABSENT = 2'd1;
  localparam logic [1:0] FLT_PROT   = 2'd2;
endpackage

// File: rtl/pw_addr.sv
module pw_addr #(
  parameter int AW       = 32,
  parameter int DIR_BITS = 10,
  parameter int TBL_BITS = 10,
  parameter int OFF_BITS = 12,
  parameter int ENT_LG   = 2
) (
  input  logic [AW-1:0]          base,
  input  logic [DIR_BITS-1:0]    dir_idx,
  input  logic [TBL_BITS-1:0]    tbl_idx,
  input  logic [AW-OFF_BITS-1:0] tbl_frame,
  output logic [AW-1:0]          dir_addr,
  output logic [AW-1:0]          tbl_addr
);
  // Entries are 2**ENT_LG bytes, so an index is scaled by that amount.
  assign dir_addr = base + (AW'(dir_idx) << ENT_LG);
  assign tbl_addr = {tbl_frame, {OFF_BITS{1'b0}}} | (AW'(tbl_idx) << ENT_LG);
endmodule

// File: rtl/pw_perm.sv
module pw_perm (
  input  logic up_rw,
  input  logic up_us,
  input  logic lo_rw,
  input  logic lo_us,
  input  logic is_write,
  input  logic is_user,
  output logic deny
);
  // Rights of both levels are merged: the most restrictive one wins.
  assign deny = (is_write && !(up_rw && lo_rw)) ||
                (is_user  && !(up_us && lo_us));
endmodule

// File: rtl/pw_upd.sv
module pw_upd #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] entry,
  input  logic          set_dirty,
  output logic [AW-1:0] new_entry,
  output logic          need
);
  import pw_pkg::*;
  logic [AW-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[BIT_ACC] = 1'b1;
    set_mask[BIT_DRT] = set_dirty;
  end

  assign new_entry = entry | set_mask;
  assign need      = (new_entry != entry);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW       = 32,
  parameter int DIR_BITS = 10,
  parameter int TBL_BITS = 10,
  parameter int OFF_BITS = 12,
  parameter int ENT_LG   = 2,
  parameter int LARGE_EN = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base_addr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic          req_write,
  input  logic          req_user,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_paddr,
  output logic [1:0]    rsp_fault,
  output logic [1:0]    rsp_level,
  output logic          rsp_large,
  output logic          mem_rd_valid,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_ack,
  input  logic [AW-1:0] mem_rd_data,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [AW-1:0] mem_wr_data,
  input  logic          mem_wr_ack
);
  import pw_pkg::*;

  localparam int LG_OFF = TBL_BITS + OFF_BITS;

  walk_state_t   state;
  logic [AW-1:0] vaddr_q, pde_q, pde_addr_q, last_addr_q, last_data_q;
  logic          wr_q, user_q, last_need_q;

  logic [AW-1:0] cur_va, dir_addr, tbl_addr;
  logic [AW-1:0] upd_in, dir_new, tbl_new;
  logic [AW-1:0] up_ent;
  logic          dir_need, tbl_need, deny, large_hit, dir_dirty;
  logic [AW-1:0] large_pa, small_pa;

  assign req_ready = (state == ST_IDLE);

  // Address generation
  assign cur_va = (state == ST_IDLE) ? req_vaddr : vaddr_q;

  pw_addr #(
    .AW(AW), .DIR_BITS(DIR_BITS), .TBL_BITS(TBL_BITS),
    .OFF_BITS(OFF_BITS), .ENT_LG(ENT_LG)
  ) u_addr (
    .base      (base_addr),
    .dir_idx   (cur_va[AW-1 -: DIR_BITS]),
    .tbl_idx   (cur_va[OFF_BITS +: TBL_BITS]),
    .tbl_frame (mem_rd_data[AW-1:OFF_BITS]),
    .dir_addr  (dir_addr),
    .tbl_addr  (tbl_addr)
  );

  // Permission merge
  assign up_ent = (state == ST_RD_DIR) ? mem_rd_data : pde_q;

  pw_perm u_perm (
    .up_rw    (up_ent[BIT_RW]),
    .up_us    (up_ent[BIT_US]),
    .lo_rw    (mem_rd_data[BIT_RW]),
    .lo_us    (mem_rd_data[BIT_US]),
    .is_write (wr_q),
    .is_user  (user_q),
    .deny     (deny)
  );

  // Status-bit update for the directory entry (final entry when large)
  assign upd_in    = up_ent;
  assign dir_dirty = (state == ST_RD_DIR) ? wr_q : 1'b0;

  pw_upd #(.AW(AW)) u_upd_dir (
    .entry     (upd_in),
    .set_dirty (dir_dirty),
    .new_entry (dir_new),
    .need      (dir_need)
  );

  pw_upd #(.AW(AW)) u_upd_tbl (
    .entry     (mem_rd_data),
    .set_dirty (wr_q),
    .new_entry (tbl_new),
    .need      (tbl_need)
  );

  generate
    if (LARGE_EN != 0) begin : g_large
      assign large_hit = mem_rd_data[BIT_PS];
    end else begin : g_small_only
      assign large_hit = 1'b0;
    end
  endgenerate

  assign large_pa = {mem_rd_data[AW-1:LG_OFF], vaddr_q[LG_OFF-1:0]};
  assign small_pa = {mem_rd_data[AW-1:OFF_BITS], vaddr_q[OFF_BITS-1:0]};

  // Walk sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      vaddr_q      <= '0;
      pde_q        <= '0;
      pde_addr_q   <= '0;
      last_addr_q  <= '0;
      last_data_q  <= '0;
      last_need_q  <= 1'b0;
      wr_q         <= 1'b0;
      user_q       <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_fault    <= FLT_NONE;
      rsp_level    <= 2'd0;
      rsp_large    <= 1'b0;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q      <= req_vaddr;
            wr_q         <= req_write;
            user_q       <= req_user;
            pde_addr_q   <= dir_addr;
            mem_rd_valid <= 1'b1;
            mem_rd_addr  <= dir_addr;
            rsp_paddr    <= '0;
            rsp_fault    <= FLT_NONE;
            rsp_level    <= 2'd0;
            rsp_large    <= 1'b0;
            state        <= ST_RD_DIR;
          end
        end
        ST_RD_DIR: begin
          if (mem_rd_ack) begin
            pde_q        <= mem_rd_data;
            mem_rd_valid <= 1'b0;
            rsp_level    <= 2'd1;
            if (!mem_rd_data[BIT_P]) begin
              rsp_fault <= FLT_ABSENT;
              rsp_valid <= 1'b1;
              state     <= ST_RESP;
            end else if (large_hit) begin
              rsp_large <= 1'b1;
              if (deny) begin
                rsp_fault <= FLT_PROT;
                rsp_valid <= 1'b1;
                state     <= ST_RESP;
              end else begin
                rsp_paddr <= large_pa;
                if (dir_need) begin
                  mem_wr_valid <= 1'b1;
                  mem_wr_addr  <= pde_addr_q;
                  mem_wr_data  <= dir_new;
                  state        <= ST_WR_LAST;
                end else begin
                  rsp_valid <= 1'b1;
                  state     <= ST_RESP;
                end
              end
            end else begin
              mem_rd_valid <= 1'b1;
              mem_rd_addr  <= tbl_addr;
              state        <= ST_RD_TBL;
            end
          end
        end
        ST_RD_TBL: begin
          if (mem_rd_ack) begin
            mem_rd_valid <= 1'b0;
            rsp_level    <= 2'd2;
            if (!mem_rd_data[BIT_P]) begin
              rsp_fault <= FLT_ABSENT;
              rsp_valid <= 1'b1;
              state     <= ST_RESP;
            end else if (deny) begin
              rsp_fault <= FLT_PROT;
              rsp_valid <= 1'b1;
              state     <= ST_RESP;
            end else begin
              rsp_paddr   <= small_pa;
              last_addr_q <= mem_rd_addr;
              last_data_q <= tbl_new;
              last_need_q <= tbl_need;
              if (dir_need) begin
                mem_wr_valid <= 1'b1;
                mem_wr_addr  <= pde_addr_q;
                mem_wr_data  <= dir_new;
                state        <= ST_WR_DIR;
              end else if (tbl_need) begin
                mem_wr_valid <= 1'b1;
                mem_wr_addr  <= mem_rd_addr;
                mem_wr_data  <= tbl_new;
                state        <= ST_WR_LAST;
              end else begin
                rsp_valid <= 1'b1;
                state     <= ST_RESP;
              end
            end
          end
        end
        ST_WR_DIR: begin
          if (mem_wr_ack) begin
            if (last_need_q) begin
              mem_wr_addr <= last_addr_q;
              mem_wr_data <= last_data_q;
              state       <= ST_WR_LAST;
            end else begin
              mem_wr_valid <= 1'b0;
              rsp_valid    <= 1'b1;
              state        <= ST_RESP;
            end
          end
        end
        ST_WR_LAST: begin
          if (mem_wr_ack) begin
            mem_wr_valid <= 1'b0;
            rsp_valid    <= 1'b1;
            state        <= ST_RESP;
          end
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [1:0]    rsp_fault,
  input logic [1:0]    rsp_level,
  input logic          rsp_large,
  input logic          mem_rd_valid,
  input logic [AW-1:0] mem_rd_addr,
  input logic          mem_rd_ack,
  input logic          mem_wr_valid,
  input logic [AW-1:0] mem_wr_addr,
  input logic [AW-1:0] mem_wr_data,
  input logic          mem_wr_ack
);
  logic wrote;

  always_ff @(posedge clk) begin
    if (rst || (req_valid && req_ready)) wrote <= 1'b0;
    else if (mem_wr_valid && mem_wr_ack) wrote <= 1'b1;
  end

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_large_level_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_large) |-> (rsp_level == 2'd1));

  assert_fault_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'd0) |-> !wrote);

  assert_wr_sets_acc_R7: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> mem_wr_data[5]);

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ack) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_no_rdwr_R9: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_valid && mem_wr_valid));

  assert_idle_after_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (req_ready && !rsp_valid));
endmodule

bind pt_walker pw_checker #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_level    (rsp_level),
  .rsp_large    (rsp_large),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rd_ack   (mem_rd_ack),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .mem_wr_ack   (mem_wr_ack)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam logic [31:0] BASE = 32'hABCD_C000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] base_addr = BASE;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_large;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault, rsp_level;
  logic        mem_rd_valid, mem_wr_valid;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic        mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
  logic [31:0] mem_rd_data = '0;

  logic [31:0] mem [0:4095];
  int n_chk = 0;
  int n_err = 0;
  int rd_wait = 0;
  int wr_wait = 0;

  always #5 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst(rst), .base_addr(base_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_level(rsp_level), .rsp_large(rsp_large),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: answers each request after a random delay of 0..2 cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_ack) mem_rd_ack = 1'b0;
      else if (mem_rd_valid) begin
        if (rd_wait == 0) begin
          mem_rd_ack  = 1'b1;
          mem_rd_data = mem[mem_rd_addr[13:2]];
          rd_wait     = int'($urandom % 3);
        end else rd_wait--;
      end
      if (mem_wr_ack) mem_wr_ack = 1'b0;
      else if (mem_wr_valid) begin
        if (wr_wait == 0) begin
          mem_wr_ack = 1'b1;
          mem[mem_wr_addr[13:2]] = mem_wr_data;
          wr_wait    = int'($urandom % 3);
        end else wr_wait--;
      end
    end
  end

  task automatic do_walk(input logic [31:0] va, input logic wr, input logic usr,
                         input bit junk);
    logic [31:0] pde, pte, e_pa, n_pde, n_pte;
    logic [1:0]  e_kind, e_lvl;
    logic        e_large, small_ok;
    int          pde_i, pte_i, cyc;
    pde_i = int'(va[31:22]);
    pde   = mem[pde_i];
    pte_i = int'({pde[13:12], va[21:12]});
    pte   = mem[pte_i];
    e_pa = '0; e_large = 1'b0; n_pde = pde; n_pte = pte; small_ok = 1'b0;
    if (!pde[0]) begin
      e_kind = 2'd1; e_lvl = 2'd1;
    end else if (pde[7]) begin
      e_large = 1'b1; e_lvl = 2'd1;
      if ((wr && !pde[1]) || (usr && !pde[2])) e_kind = 2'd2;
      else begin
        e_kind = 2'd0; e_pa = {pde[31:22], va[21:0]};
        n_pde = pde | 32'h20 | (wr ? 32'h40 : 32'h0);
      end
    end else begin
      e_lvl = 2'd2; small_ok = 1'b1;
      if (!pte[0]) e_kind = 2'd1;
      else if ((wr && !(pde[1] && pte[1])) || (usr && !(pde[2] && pte[2]))) e_kind = 2'd2;
      else begin
        e_kind = 2'd0; e_pa = {pte[31:12], va[11:0]};
        n_pde = pde | 32'h20;
        n_pte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
      end
    end

    @(negedge clk);
    chk("R1 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    @(negedge clk);
    chk("R1 busy after accept", 32'(req_ready), 32'd0);
    if (junk) begin
      req_vaddr = $urandom; req_write = ~wr; req_user = ~usr;
    end else req_valid = 1'b0;
    cyc = 0;
    while (!rsp_valid && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    if (!rsp_valid) begin
      n_chk++; n_err++;
      $display("FAIL R10 watchdog: no response actual=0 expected=1");
      return;
    end
    chk("R5 R6 fault kind", 32'(rsp_fault), 32'(e_kind));
    chk("R3 R4 R5 level", 32'(rsp_level), 32'(e_lvl));
    chk("R3 R4 paddr", rsp_paddr, e_pa);
    chk("R4 large flag", 32'(rsp_large), 32'(e_large));
    @(negedge clk);
    chk("R10 single pulse", 32'(rsp_valid), 32'd0);
    chk("R1 idle, held request ignored", 32'(req_ready), 32'd1);
    chk("R1 no new read", 32'(mem_rd_valid), 32'd0);
    chk("R7 R8 directory entry", mem[pde_i], n_pde);
    if (small_ok) chk("R7 R8 table entry", mem[pte_i], n_pte);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin
      logic [31:0] r;
      r = $urandom;
      r[13:12] = 2'(1 + ($urandom % 3));
      r[0] = ($urandom % 8) != 0;
      r[7] = ($urandom % 4) == 0;
      mem[i] = r;
    end
    for (int i = 1024; i < 4096; i++) begin
      logic [31:0] r;
      r = $urandom;
      r[0] = ($urandom % 8) != 0;
      mem[i] = r;
    end
    repeat (3) @(negedge clk);
    chk("R10 reset ready", 32'(req_ready), 32'd1);
    chk("R10 reset rsp", 32'(rsp_valid), 32'd0);
    chk("R10 reset rd", 32'(mem_rd_valid), 32'd0);
    chk("R10 reset wr", 32'(mem_wr_valid), 32'd0);
    rst = 1'b0;

    // R4 R8: large page, write, flags clear, bits 9..11 set
    mem[10'h012] = 32'h5540_0E87;
    do_walk(32'h0483_4567, 1'b1, 1'b0, 1'b1);
    chk("R4 R8 large write-back", mem[10'h012], 32'h5540_0EE7);
    // R5: directory entry absent
    mem[10'h013] = 32'hFFFF_FFFE;
    do_walk(32'h04C0_0123, 1'b0, 1'b0, 1'b0);
    // R2 R3 R7: small page, both entries need update, user write
    mem[10'h014] = 32'h0000_1007;
    mem[1024 + 10'h005] = 32'h1234_5E07;
    do_walk(32'h0500_5ABC, 1'b1, 1'b1, 1'b1);
    chk("R3 R7 pte updated", mem[1024 + 10'h005], 32'h1234_5E67);
    // R6: user read through supervisor-only directory entry
    mem[10'h015] = 32'h0000_2063;
    mem[2048 + 10'h007] = 32'h2222_2067;
    do_walk(32'h0540_7000, 1'b0, 1'b1, 1'b0);
    // R6: supervisor ignores U/S; supervisor write to read-only table entry
    do_walk(32'h0540_7004, 1'b0, 1'b0, 1'b0);
    mem[2048 + 10'h008] = 32'h3333_3065;
    do_walk(32'h0540_8000, 1'b1, 1'b0, 1'b0);
    // R5: table entry absent
    mem[2048 + 10'h009] = 32'h4444_40E6;
    do_walk(32'h0540_9FFF, 1'b0, 1'b0, 1'b0);

    for (int k = 0; k < 400; k++)
      do_walk($urandom, 1'($urandom), 1'($urandom), 1'($urandom));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R10 global watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule